// File: doc/BRIEF.md
# SIMD Low-Half Interleave Unit

This block merges two vector operands by alternating their low-order elements. For each 128-bit lane it takes the lower half of source A and the lower half of source B. It then writes the elements alternately, starting with A: A0, B0, A1, B1 and so on, from least significant upward. The upper halves of both sources play no part in the result. The element size can be 8, 16, 32 or 64 bits.

The unit works on 256-bit vectors in one of two ways. In wide mode, each 128-bit lane is interleaved on its own, from the low half of that same lane. In narrow mode, only lane 0 is interleaved. The upper 128 bits of the result then either copy the previous destination value or are cleared, as chosen by a policy input. The unit has a single register stage. A result is captured when the input strobe is high and held until the next strobe. The output strobe follows the input strobe one clock later.

Top module: `lowhalf_interleave`

## Requirements
- R1: Bits in the upper half of each 128-bit lane of `src_a` and `src_b` have no effect on `result`.
- R2: Within a lane, element i of A goes to output element 2i and element i of B goes to output element 2i+1. A0 is always in the least significant position.
- R3: `elem_size` selects the element width: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 is 32 bits and 2'b11 is 64 bits.
- R4: With `wide_mode`=1, bits 255:128 are interleaved from `src_a[191:128]` and `src_b[191:128]`. At 32-bit size this gives A4, B4, A5, B5 from low to high.
- R5: With `wide_mode`=0 and `clear_upper`=0, `result[255:128]` equals `dst_old[255:128]` as presented with the strobe.
- R6: With `wide_mode`=0 and `clear_upper`=1, `result[255:128]` is zero.
- R7: At 64-bit size, a lane yields A0 in its low quadword and B0 in its high quadword.
- R8: With `wide_mode`=1, `clear_upper` has no effect on `result`.
- R9: `out_valid` equals `in_valid` delayed by exactly one clock.
- R10: A synchronous active-high `rst` clears `result` and `out_valid`.
- R11: When `in_valid` is low, `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid; capture the result |
| elem_size | input | 2 | Element width code (see R3) |
| wide_mode | input | 1 | 1: 256-bit per-lane interleave, 0: 128-bit |
| clear_upper | input | 1 | Narrow mode only: 1 clears bits 255:128, 0 keeps them |
| src_a | input | 256 | First source; its elements come first |
| src_b | input | 256 | Second source |
| dst_old | input | 256 | Previous destination value |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 256 | Registered interleave result |

## Verification
The assertions assume that `src_a`, `src_b`, `dst_old`, `elem_size`, `wide_mode` and `clear_upper` are stable and known on every clock where `in_valid` is high. They also assume that reset is held for at least one edge before the first strobe. The bench meets these assumptions by changing inputs only on falling edges. It raises the strobe only after a reset of several cycles, and it drives every operand to a defined value, including during idle cycles. Since the checks on held results compare against inputs sampled with the strobe, the bench changes the operands freely while the strobe is low.

// File: rtl/lhi_pkg.sv
package lhi_pkg;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'b00,
    ESZ_W16 = 2'b01,
    ESZ_D32 = 2'b10,
    ESZ_Q64 = 2'b11
  } esz_e;

  // Element width in bits for a size code.
  function automatic int unsigned esz_bits(input esz_e sz);
    return 32'd8 << sz;
  endfunction

  // Number of elements taken from each source in one lane.
  function automatic int unsigned pairs_per_lane(input int unsigned lane_w, input esz_e sz);
    return lane_w / (2 * esz_bits(sz));
  endfunction

endpackage

// File: rtl/lhi_lane.sv
module lhi_lane
  import lhi_pkg::*;
#(
  parameter int unsigned LANE_W = 128
) (
  input  logic [LANE_W/2-1:0] a_half,
  input  logic [LANE_W/2-1:0] b_half,
  input  esz_e                esz,
  output logic [LANE_W-1:0]   lane_out
);
  localparam int unsigned NUM_SZ = 4;
  localparam int unsigned HALF_W = LANE_W / 2;

  logic [NUM_SZ*LANE_W-1:0] cand_flat;

  generate
    for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
      localparam int unsigned EW    = 8 << k;
      localparam int unsigned PAIRS = HALF_W / EW;
      for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign cand_flat[k*LANE_W + (2*i)*EW   +: EW] = a_half[i*EW +: EW];
        assign cand_flat[k*LANE_W + (2*i+1)*EW +: EW] = b_half[i*EW +: EW];
      end
    end
  endgenerate

  always_comb begin
    case (esz)
      ESZ_B8:  lane_out = cand_flat[0*LANE_W +: LANE_W];
      ESZ_W16: lane_out = cand_flat[1*LANE_W +: LANE_W];
      ESZ_D32: lane_out = cand_flat[2*LANE_W +: LANE_W];
      default: lane_out = cand_flat[3*LANE_W +: LANE_W];
    endcase
  end

endmodule

// File: rtl/lhi_upper.sv
module lhi_upper #(
  parameter int unsigned LANE_W    = 128,
  parameter int unsigned NUM_LANES = 2
) (
  input  logic [LANE_W*NUM_LANES-1:0]     ilv_all,
  input  logic [LANE_W*(NUM_LANES-1)-1:0] old_upper,
  input  logic                            wide,
  input  logic                            clear,
  output logic [LANE_W*NUM_LANES-1:0]     merged
);
  assign merged[LANE_W-1:0] = ilv_all[LANE_W-1:0];

  generate
    for (genvar l = 1; l < NUM_LANES; l++) begin : g_lane
      always_comb begin
        if (wide)       merged[l*LANE_W +: LANE_W] = ilv_all[l*LANE_W +: LANE_W];
        else if (clear) merged[l*LANE_W +: LANE_W] = '0;
        else            merged[l*LANE_W +: LANE_W] = old_upper[(l-1)*LANE_W +: LANE_W];
      end
    end
  endgenerate

endmodule

// File: rtl/lowhalf_interleave.sv
module lowhalf_interleave
  import lhi_pkg::*;
#(
  parameter int unsigned LANE_W    = 128,
  parameter int unsigned NUM_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [1:0]                  elem_size,
  input  logic                        wide_mode,
  input  logic                        clear_upper,
  input  logic [LANE_W*NUM_LANES-1:0] src_a,
  input  logic [LANE_W*NUM_LANES-1:0] src_b,
  input  logic [LANE_W*NUM_LANES-1:0] dst_old,
  output logic                        out_valid,
  output logic [LANE_W*NUM_LANES-1:0] result
);
  localparam int unsigned DATA_W = LANE_W * NUM_LANES;
  localparam int unsigned HALF_W = LANE_W / 2;

  esz_e              esz;
  logic [DATA_W-1:0] ilv_all;
  logic [DATA_W-1:0] merged;

  // Named events for the assertions.
  logic ev_load;
  logic ev_keep_upper;
  logic ev_clear_upper;

  assign esz            = esz_e'(elem_size);
  assign ev_load        = in_valid;
  assign ev_keep_upper  = in_valid && !wide_mode && !clear_upper;
  assign ev_clear_upper = in_valid && !wide_mode && clear_upper;

  // Bits that by definition play no part in the result.
  logic unused_bits;
  generate
    if (NUM_LANES > 1) begin : g_unused
      logic [NUM_LANES*HALF_W*2-1:0] hi_halves;
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_hi
        assign hi_halves[l*2*HALF_W +: 2*HALF_W] =
          {src_a[l*LANE_W+HALF_W +: HALF_W], src_b[l*LANE_W+HALF_W +: HALF_W]};
      end
      assign unused_bits = ^{hi_halves, dst_old[LANE_W-1:0]};
    end else begin : g_unused1
      assign unused_bits = ^{src_a[LANE_W-1:HALF_W], src_b[LANE_W-1:HALF_W],
                             dst_old, wide_mode, clear_upper};
    end
  endgenerate

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      lhi_lane #(.LANE_W(LANE_W)) i_lane (
        .a_half  (src_a[l*LANE_W +: HALF_W]),
        .b_half  (src_b[l*LANE_W +: HALF_W]),
        .esz     (esz),
        .lane_out(ilv_all[l*LANE_W +: LANE_W])
      );
    end

    if (NUM_LANES > 1) begin : g_upper
      lhi_upper #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) i_upper (
        .ilv_all  (ilv_all),
        .old_upper(dst_old[DATA_W-1:LANE_W]),
        .wide     (wide_mode),
        .clear    (clear_upper),
        .merged   (merged)
      );
    end else begin : g_single
      assign merged = ilv_all;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (ev_load) result <= merged;
    end
  end

  // Assertions
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> (!out_valid && result == '0));

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_low_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_a0_lowest_r2: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> result[7:0] == $past(src_a[7:0]));

  p_qword_b0_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_load && elem_size == 2'b11) |=> result[LANE_W-1:HALF_W] == $past(src_b[HALF_W-1:0]));

  generate
    if (NUM_LANES > 1) begin : g_upper_chk
      p_keep_upper_r5: assert property (@(posedge clk) disable iff (rst)
        ev_keep_upper |=> result[DATA_W-1:LANE_W] == $past(dst_old[DATA_W-1:LANE_W]));

      p_clear_upper_r6: assert property (@(posedge clk) disable iff (rst)
        ev_clear_upper |=> result[DATA_W-1:LANE_W] == '0);
    end
  endgenerate

endmodule

// File: tb/test_lowhalf_interleave.sv
`timescale 1ns/1ps
module test_lowhalf_interleave;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   elem_size = 2'b00;
  logic         wide_mode = 1'b0;
  logic         clear_upper = 1'b0;
  logic [255:0] src_a = '0, src_b = '0, dst_old = '0;
  logic         out_valid;
  logic [255:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lowhalf_interleave i_lowhalf_interleave (
    .clk(clk), .rst(rst), .in_valid(in_valid), .elem_size(elem_size),
    .wide_mode(wide_mode), .clear_upper(clear_upper), .src_a(src_a),
    .src_b(src_b), .dst_old(dst_old), .out_valid(out_valid), .result(result)
  );

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Reference: per lane, walk element indices of the low half.
  function automatic logic [255:0] model(input logic [255:0] a, b, old,
                                         input logic [1:0] sz, input logic wide, clr);
    logic [255:0] r = '0;
    int ew = 8 << sz;
    int half = 64 / ew;
    for (int l = 0; l < 2; l++) begin
      if (l == 1 && !wide) begin
        for (int j = 128; j < 256; j++) r[j] = clr ? 1'b0 : old[j];
      end else begin
        for (int i = 0; i < half; i++)
          for (int j = 0; j < ew; j++) begin
            r[l*128 + 2*i*ew + j]     = a[l*128 + i*ew + j];
            r[l*128 + (2*i+1)*ew + j] = b[l*128 + i*ew + j];
          end
      end
    end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [255:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One strobe; returns the registered result one clock later.
  task automatic apply(input logic [255:0] a, b, old, input logic [1:0] sz,
                       input logic wide, clr, output logic [255:0] res, output logic vld);
    @(negedge clk);
    src_a = a; src_b = b; dst_old = old;
    elem_size = sz; wide_mode = wide; clear_upper = clr;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res = result;
    vld = out_valid;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_vec("R10 result after reset", result, '0);
    check_vec("R10 out_valid after reset", {255'd0, out_valid}, '0);
    rst = 1'b0;
  endtask

  task automatic t_all_modes();
    logic [255:0] pa [4], pb [4];
    logic [255:0] res;
    logic vld;
    pa[0] = rnd256(); pb[0] = rnd256();
    pa[1] = '1;       pb[1] = '0;
    pa[2] = {64{4'b0101}}; pb[2] = {64{4'b1010}};
    for (int k = 0; k < 32; k++) begin
      pa[3][k*8 +: 8] = 8'(k);
      pb[3][k*8 +: 8] = 8'(8'h80 | k);
    end
    for (int p = 0; p < 4; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int m = 0; m < 3; m++) begin
          logic w = (m == 2);
          logic c = (m == 1);
          logic [255:0] old = rnd256();
          apply(pa[p], pb[p], old, 2'(sz), w, c, res, vld);
          check_vec($sformatf("R2 R3 pattern %0d size %0d mode %0d", p, sz, m),
                    res, model(pa[p], pb[p], old, 2'(sz), w, c));
        end
  endtask

  task automatic t_high_ignored();
    logic [255:0] a = rnd256(), b = rnd256(), old = rnd256();
    logic [255:0] r1, r2;
    logic vld;
    for (int sz = 0; sz < 4; sz++) begin
      apply(a, b, old, 2'(sz), 1'b1, 1'b0, r1, vld);
      a[255:192] = ~a[255:192]; a[127:64] = ~a[127:64];
      b[255:192] = rnd256()[63:0]; b[127:64] = ~b[127:64];
      apply(a, b, old, 2'(sz), 1'b1, 1'b0, r2, vld);
      check_vec($sformatf("R1 high halves ignored size %0d", sz), r2, r1);
    end
  endtask

  task automatic t_lane_dword();
    logic [255:0] a = rnd256(), b = rnd256(), res;
    logic vld;
    apply(a, b, '0, 2'b10, 1'b1, 1'b0, res, vld);
    check_vec("R4 upper lane A4,B4,A5,B5", {128'd0, res[255:128]},
              {128'd0, b[191:160], a[191:160], b[159:128], a[159:128]});
  endtask

  task automatic t_upper_policy();
    logic [255:0] a = rnd256(), b = rnd256(), old = rnd256(), res;
    logic vld;
    apply(a, b, old, 2'b00, 1'b0, 1'b0, res, vld);
    check_vec("R5 keep upper", {128'd0, res[255:128]}, {128'd0, old[255:128]});
    apply(a, b, '1, 2'b01, 1'b0, 1'b1, res, vld);
    check_vec("R6 clear upper", {128'd0, res[255:128]}, '0);
  endtask

  task automatic t_qword();
    logic [255:0] a = rnd256(), b = rnd256(), res;
    logic vld;
    apply(a, b, '0, 2'b11, 1'b1, 1'b1, res, vld);
    check_vec("R7 qword lanes", res, {b[191:128], a[191:128], b[63:0], a[63:0]});
  endtask

  task automatic t_wide_ignores_policy();
    logic [255:0] a = rnd256(), b = rnd256(), old = rnd256(), r1, r2;
    logic vld;
    apply(a, b, old, 2'b01, 1'b1, 1'b0, r1, vld);
    apply(a, b, old, 2'b01, 1'b1, 1'b1, r2, vld);
    check_vec("R8 clear_upper ignored in wide mode", r2, r1);
  endtask

  task automatic t_valid_and_hold();
    logic [255:0] a = rnd256(), b = rnd256(), res;
    logic vld;
    apply(a, b, '0, 2'b00, 1'b1, 1'b0, res, vld);
    check_vec("R9 out_valid one clock after strobe", {255'd0, vld}, 256'd1);
    src_a = ~a; src_b = ~b; elem_size = 2'b11;
    @(negedge clk);
    check_vec("R9 out_valid drops", {255'd0, out_valid}, '0);
    repeat (3) @(negedge clk);
    check_vec("R11 result held while idle", result, res);
  endtask

  task automatic t_mid_reset();
    logic [255:0] res;
    logic vld;
    apply('1, '1, '1, 2'b00, 1'b1, 1'b0, res, vld);
    rst = 1'b1;
    @(negedge clk);
    check_vec("R10 reset clears result", result, '0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_all_modes();
    t_high_ignored();
    t_lane_dword();
    t_upper_policy();
    t_qword();
    t_wide_ignores_policy();
    t_valid_and_hold();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule